// File: doc/BRIEF.md
# Trace packet enable controller

This block decides when an instruction-trace unit is allowed to emit control-flow packets. It combines four enables into one packet enable. The trigger enable follows the software trace-on bit, and stop or error events cut it. The context enable comes from the privilege level, the enclave state and a page-table-base match. The filter enable comes from an address-filter result. The branch enable comes from a configuration bit. Timing and bookkeeping packets are gated by the trigger enable alone.

Two status bits, stopped and error, are sticky. Software can only write them while trace-on is low, and trace-on cannot re-arm the trigger while either bit is set. The block reports each rise of the packet enable with a one-cycle enable-packet request and each fall with a one-cycle disable-packet request. The disable request carries a flag that suppresses its address payload when the fall is caused by the context enable dropping. The packet encoder downstream consumes these requests.

Top module: `trace_gate`

## Requirements
- R1: While `rst_ni` is low, every output is 0.
- R2: `trig_en_o` becomes 1 at the first clock edge where `cfg_trace_on_i` is 1 and neither status bit is set or being set. It becomes 0 at the first edge where `cfg_trace_on_i` is 0.
- R3: A `stop_evt_i` (or `error_evt_i`) pulse while `trig_en_o` is 1 sets `stopped_o` (or `error_o`) and clears `trig_en_o` at the same edge. With `trig_en_o` at 0 the event has no effect.
- R4: `stopped_o` and `error_o` hold their value except at an edge where `sts_wr_i` is 1 and `cfg_trace_on_i` is 0. At such an edge they load `sts_stop_wdata_i` and `sts_err_wdata_i`. If an event sets a bit at the same edge, the event wins. While either bit is 1, `trig_en_o` stays 0.
- R5: At each edge where the trigger is loaded with 1, `ctx_en_o` loads 0 if any of these holds, and 1 otherwise:
  - `priv_lvl_i` is 0 and `cfg_kernel_i` is 0;
  - `priv_lvl_i` is not 0 and `cfg_user_i` is 0;
  - `enclave_prod_i` is 1;
  - `cfg_as_filt_i` is 1 and `ptb_i` differs from `ptb_match_i`.
- R6: At an edge where the trigger is loaded with 0, `ctx_en_o` keeps its value.
- R7: The filter enable is registered each edge. It is 1 when `filt_supported_i` is 0, and otherwise it equals `addr_filt_hit_i`.
- R8: The branch enable is `cfg_branch_i`, registered each edge.
- R9: `pkt_en_o` is the AND of the trigger, context, filter and branch enables. `timing_en_o` equals `trig_en_o`.
- R10: `pge_req_o` is 1 for exactly the first cycle in which `pkt_en_o` is 1 after a cycle in which it was 0.
- R11: `pgd_req_o` is 1 for exactly the first cycle in which `pkt_en_o` is 0 after a cycle in which it was 1. `pgd_nopay_o` is 1 only in such a cycle, and only if `ctx_en_o` also went from 1 to 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_trace_on_i | input | 1 | Software trace-on bit |
| cfg_kernel_i | input | 1 | Trace privilege level 0 |
| cfg_user_i | input | 1 | Trace privilege levels above 0 |
| cfg_as_filt_i | input | 1 | Address-space (page-table-base) filter on |
| cfg_branch_i | input | 1 | Branch trace enable |
| priv_lvl_i | input | PRIV_W | Current privilege level |
| enclave_prod_i | input | 1 | Executing inside a production enclave |
| ptb_i | input | PTB_W | Current page-table base |
| ptb_match_i | input | PTB_W | Programmed page-table-base match value |
| addr_filt_hit_i | input | 1 | Address-filter result |
| filt_supported_i | input | 1 | Strap: address filtering implemented |
| stop_evt_i | input | 1 | Stop condition event |
| error_evt_i | input | 1 | Operational error event |
| sts_wr_i | input | 1 | Software write strobe for status bits |
| sts_stop_wdata_i | input | 1 | Write value for stopped bit |
| sts_err_wdata_i | input | 1 | Write value for error bit |
| trig_en_o | output | 1 | Trigger enable |
| ctx_en_o | output | 1 | Context enable |
| pkt_en_o | output | 1 | Packet enable for control-flow packets |
| timing_en_o | output | 1 | Enable for timing and bookkeeping packets |
| stopped_o | output | 1 | Sticky stopped status |
| error_o | output | 1 | Sticky error status |
| pge_req_o | output | 1 | Enable-packet request pulse |
| pgd_req_o | output | 1 | Disable-packet request pulse |
| pgd_nopay_o | output | 1 | Suppress the disable packet's address payload |

## Verification
The bench builds the block with `PTB_W` = 12 and `PRIV_W` = 2. The narrow page-table base lets random stimulus hit equal and unequal match values often, so the address-space filter term toggles in both directions. Two privilege bits give the level-0 case plus three distinct non-zero levels. This shows that every level above 0 follows the user-trace bit. Directed sequences cover the interactions between sticky status and re-arming, and between a frozen context and a changing privilege level.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;

  typedef struct packed {
    logic trace_on;
    logic kernel;
    logic user;
    logic as_filt;
    logic branch;
  } tg_cfg_t;

  typedef struct packed {
    logic stopped;
    logic error;
  } tg_sts_t;

endpackage

// File: rtl/trace_gate_trigger.sv
module trace_gate_trigger
  import trace_gate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    trace_on_i,
  input  logic    stop_evt_i,
  input  logic    error_evt_i,
  input  logic    sts_wr_i,
  input  tg_sts_t sts_wdata_i,
  output logic    trig_d_o,
  output logic    trig_q_o,
  output tg_sts_t sts_o
);

  tg_sts_t sts_q, sts_d;
  logic    trig_q, trig_d;
  logic    sw_write_ok;

  assign sw_write_ok = sts_wr_i & ~trace_on_i;

  always_comb begin
    sts_d = sts_q;
    if (sw_write_ok) sts_d = sts_wdata_i;
    // events only count while tracing; they win over a write
    if (stop_evt_i  && trig_q) sts_d.stopped = 1'b1;
    if (error_evt_i && trig_q) sts_d.error   = 1'b1;
    trig_d = trace_on_i & ~sts_d.stopped & ~sts_d.error;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      trig_q <= trig_d;
    end
  end

  assign trig_d_o = trig_d;
  assign trig_q_o = trig_q;
  assign sts_o    = sts_q;

  // R3
  stop_kills_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt_i && trig_q) |=> (!trig_q && sts_q.stopped));

  // R3
  err_kills_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_evt_i && trig_q) |=> (!trig_q && sts_q.error));

  // R4
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q.stopped && !(sts_wr_i && !trace_on_i)) |=> sts_q.stopped);

  // R4
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q.stopped || sts_q.error) |-> !trig_q);

  // R2
  trig_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_on_i |=> !trig_q);

endmodule

// File: rtl/trace_gate_context.sv
module trace_gate_context #(
  parameter int unsigned PRIV_W = 2,
  parameter int unsigned PTB_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              kernel_i,
  input  logic              user_i,
  input  logic              as_filt_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              enclave_i,
  input  logic [PTB_W-1:0]  ptb_i,
  input  logic [PTB_W-1:0]  ptb_match_i,
  output logic              ctx_o
);

  localparam logic [PRIV_W-1:0] PrivTop = '0;

  logic at_top, kern_block, user_block, ptb_block, ctx_raw, ctx_q;

  assign at_top     = (priv_i == PrivTop);
  assign kern_block = at_top & ~kernel_i;
  assign user_block = ~at_top & ~user_i;
  assign ptb_block  = as_filt_i & (ptb_i != ptb_match_i);
  assign ctx_raw    = ~(kern_block | user_block | enclave_i | ptb_block);

  // frozen while trigger is being loaded with 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctx_q <= 1'b0;
    else if (load_i) ctx_q <= ctx_raw;
  end

  assign ctx_o = ctx_q;

  // R6
  ctx_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ctx_q));

  // R5
  ctx_enclave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && enclave_i) |=> !ctx_q);

endmodule

// File: rtl/trace_gate_edge.sv
module trace_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic ctx_i,
  input  logic filt_i,
  input  logic br_i,
  output logic pkt_en_o,
  output logic pge_o,
  output logic pgd_o,
  output logic nopay_o
);

  logic pkt_en, pkt_prev_q, ctx_prev_q, ctx_fell;

  assign pkt_en = trig_i & ctx_i & filt_i & br_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_prev_q <= 1'b0;
      ctx_prev_q <= 1'b0;
    end else begin
      pkt_prev_q <= pkt_en;
      ctx_prev_q <= ctx_i;
    end
  end

  assign ctx_fell = ctx_prev_q & ~ctx_i;
  assign pkt_en_o = pkt_en;
  assign pge_o    = pkt_en & ~pkt_prev_q;
  assign pgd_o    = ~pkt_en & pkt_prev_q;
  assign nopay_o  = pgd_o & ctx_fell;

  // R10
  pge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pge_o |=> !pge_o);

  // R11
  pgd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgd_o |=> !pgd_o);

  // R11
  nopay_needs_pgd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nopay_o |-> (pgd_o && !ctx_i));

  // R9
  pkt_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_en_o |-> trig_i);

endmodule

// File: rtl/trace_gate.sv
module trace_gate
  import trace_gate_pkg::*;
#(
  parameter int unsigned PRIV_W = 2,
  parameter int unsigned PTB_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_trace_on_i,
  input  logic              cfg_kernel_i,
  input  logic              cfg_user_i,
  input  logic              cfg_as_filt_i,
  input  logic              cfg_branch_i,
  input  logic [PRIV_W-1:0] priv_lvl_i,
  input  logic              enclave_prod_i,
  input  logic [PTB_W-1:0]  ptb_i,
  input  logic [PTB_W-1:0]  ptb_match_i,
  input  logic              addr_filt_hit_i,
  input  logic              filt_supported_i,
  input  logic              stop_evt_i,
  input  logic              error_evt_i,
  input  logic              sts_wr_i,
  input  logic              sts_stop_wdata_i,
  input  logic              sts_err_wdata_i,
  output logic              trig_en_o,
  output logic              ctx_en_o,
  output logic              pkt_en_o,
  output logic              timing_en_o,
  output logic              stopped_o,
  output logic              error_o,
  output logic              pge_req_o,
  output logic              pgd_req_o,
  output logic              pgd_nopay_o
);

  tg_cfg_t cfg;
  tg_sts_t sts_wdata, sts;
  logic    trig_d, trig_q, ctx_q, filt_q, br_q, filt_d;

  assign cfg = '{trace_on: cfg_trace_on_i, kernel: cfg_kernel_i, user: cfg_user_i,
                 as_filt: cfg_as_filt_i, branch: cfg_branch_i};
  assign sts_wdata = '{stopped: sts_stop_wdata_i, error: sts_err_wdata_i};

  trace_gate_trigger u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trace_on_i  (cfg.trace_on),
    .stop_evt_i  (stop_evt_i),
    .error_evt_i (error_evt_i),
    .sts_wr_i    (sts_wr_i),
    .sts_wdata_i (sts_wdata),
    .trig_d_o    (trig_d),
    .trig_q_o    (trig_q),
    .sts_o       (sts)
  );

  trace_gate_context #(.PRIV_W(PRIV_W), .PTB_W(PTB_W)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (trig_d),
    .kernel_i    (cfg.kernel),
    .user_i      (cfg.user),
    .as_filt_i   (cfg.as_filt),
    .priv_i      (priv_lvl_i),
    .enclave_i   (enclave_prod_i),
    .ptb_i       (ptb_i),
    .ptb_match_i (ptb_match_i),
    .ctx_o       (ctx_q)
  );

  // filter forced on when the strap says filtering is absent
  assign filt_d = filt_supported_i ? addr_filt_hit_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      br_q   <= 1'b0;
    end else begin
      filt_q <= filt_d;
      br_q   <= cfg.branch;
    end
  end

  trace_gate_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_q),
    .ctx_i    (ctx_q),
    .filt_i   (filt_q),
    .br_i     (br_q),
    .pkt_en_o (pkt_en_o),
    .pge_o    (pge_req_o),
    .pgd_o    (pgd_req_o),
    .nopay_o  (pgd_nopay_o)
  );

  assign trig_en_o   = trig_q;
  assign ctx_en_o    = ctx_q;
  assign timing_en_o = trig_q;
  assign stopped_o   = sts.stopped;
  assign error_o     = sts.error;

  // R7
  filt_strap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_supported_i |=> filt_q);

  // R8
  branch_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (br_q == $past(cfg_branch_i)));

  // R9
  timing_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_en_o == trig_en_o);

endmodule

// File: tb/tb_trace_gate.sv
module tb_trace_gate;
  localparam int PRIV_W = 2;
  localparam int PTB_W  = 12;
  localparam time CLK_P = 20ns;

  logic clk = 0, rst_n = 0;
  logic trace_on = 0, kern = 0, user = 0, asf = 0, br = 0;
  logic [PRIV_W-1:0] priv = 0;
  logic encl = 0, hit = 0, fsup = 0, stop_e = 0, err_e = 0;
  logic swr = 0, wd_stop = 0, wd_err = 0;
  logic [PTB_W-1:0] ptb = 0, ptbm = 0;
  logic trig, ctx, pkt, tim, stp, err, pge, pgd, nop;

  always #(CLK_P/2) clk = ~clk;

  trace_gate #(.PRIV_W(PRIV_W), .PTB_W(PTB_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_trace_on_i(trace_on), .cfg_kernel_i(kern),
    .cfg_user_i(user), .cfg_as_filt_i(asf), .cfg_branch_i(br), .priv_lvl_i(priv),
    .enclave_prod_i(encl), .ptb_i(ptb), .ptb_match_i(ptbm), .addr_filt_hit_i(hit),
    .filt_supported_i(fsup), .stop_evt_i(stop_e), .error_evt_i(err_e), .sts_wr_i(swr),
    .sts_stop_wdata_i(wd_stop), .sts_err_wdata_i(wd_err), .trig_en_o(trig),
    .ctx_en_o(ctx), .pkt_en_o(pkt), .timing_en_o(tim), .stopped_o(stp), .error_o(err),
    .pge_req_o(pge), .pgd_req_o(pgd), .pgd_nopay_o(nop));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_trig, m_ctx, m_filt, m_br, m_stop, m_err, m_pkt_prev, m_ctx_prev;
  int n_stop, n_err, n_trig, old_pkt, allowed;

  function automatic int m_pkt();
    return (m_trig && m_ctx && m_filt && m_br) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trig = 0; m_ctx = 0; m_filt = 0; m_br = 0; m_stop = 0; m_err = 0;
      m_pkt_prev = 0; m_ctx_prev = 0;
    end else begin
      old_pkt = m_pkt();
      n_stop = m_stop; n_err = m_err;
      if (swr && !trace_on) begin n_stop = wd_stop; n_err = wd_err; end
      if (m_trig && stop_e) n_stop = 1;
      if (m_trig && err_e)  n_err = 1;
      n_trig = (trace_on && n_stop == 0 && n_err == 0) ? 1 : 0;
      m_ctx_prev = m_ctx;
      if (n_trig == 1) begin
        allowed = 1;
        if (priv == 0 && !kern) allowed = 0;
        if (priv != 0 && !user) allowed = 0;
        if (encl) allowed = 0;
        if (asf && ptb != ptbm) allowed = 0;
        m_ctx = allowed;
      end
      m_stop = n_stop; m_err = n_err; m_trig = n_trig;
      m_filt = fsup ? int'(hit) : 1;
      m_br = int'(br);
      m_pkt_prev = old_pkt;
    end
  end

  task automatic compare_all();
    int e_pkt, e_pge, e_pgd, e_nop;
    e_pkt = m_pkt();
    e_pge = (e_pkt == 1 && m_pkt_prev == 0) ? 1 : 0;
    e_pgd = (e_pkt == 0 && m_pkt_prev == 1) ? 1 : 0;
    e_nop = (e_pgd == 1 && m_ctx_prev == 1 && m_ctx == 0) ? 1 : 0;
    chk(int'(trig) == m_trig, "R2 trig_en", trig, m_trig);
    chk(int'(ctx) == m_ctx, "R5 ctx_en", ctx, m_ctx);
    chk(int'(pkt) == e_pkt, "R9 pkt_en", pkt, e_pkt);
    chk(int'(tim) == m_trig, "R9 timing_en", tim, m_trig);
    chk(int'(stp) == m_stop, "R4 stopped", stp, m_stop);
    chk(int'(err) == m_err, "R4 error", err, m_err);
    chk(int'(pge) == e_pge, "R10 pge_req", pge, e_pge);
    chk(int'(pgd) == e_pgd, "R11 pgd_req", pgd, e_pgd);
    chk(int'(nop) == e_nop, "R11 pgd_nopay", nop, e_nop);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({trig, ctx, pkt, tim, stp, err, pge, pgd, nop} == 9'b0, "R1 reset outputs",
        {trig, ctx, pkt, tim, stp, err, pge, pgd, nop}, 0);
    rst_n = 1;
    tick();

    // bring up tracing at kernel level
    kern = 1; user = 1; br = 1; fsup = 0; trace_on = 1;
    tick();
    chk(trig && ctx && pkt && pge, "R10 first enable", pkt, 1);
    tick();

    // context drop via user level with user trace off
    user = 0; priv = 3;
    tick();
    chk(pgd && nop, "R11 ctx fall suppress", nop, 1);
    priv = 0; tick(); tick();

    // branch off: disable without suppress
    br = 0; tick();
    chk(pgd && !nop, "R8 branch fall no suppress", nop, 0);
    br = 1; ticks(2);

    // filter supported, toggle hit
    fsup = 1; hit = 0; tick();
    chk(!pkt, "R7 filter miss", pkt, 0);
    hit = 1; ticks(2);
    fsup = 0; hit = 0; tick();
    chk(pkt, "R7 strap forces filter", pkt, 1);

    // address-space filter and enclave
    asf = 1; ptb = 12'h123; ptbm = 12'h124; tick();
    chk(!ctx, "R5 ptb mismatch", ctx, 0);
    ptbm = 12'h123; tick();
    chk(ctx, "R5 ptb match", ctx, 1);
    encl = 1; tick(); encl = 0; tick(); asf = 0;

    // trigger off: context frozen
    trace_on = 0; tick();
    chk(!trig && pgd && !nop, "R2 trace off", trig, 0);
    priv = 2; user = 0; ticks(3);
    chk(ctx, "R6 ctx held while off", ctx, 1);
    trace_on = 1; tick();
    chk(trig && !ctx, "R5 ctx reloads on rearm", ctx, 0);
    priv = 0; ticks(2);

    // stop event
    stop_e = 1; tick(); stop_e = 0;
    chk(stp && !trig, "R3 stop clears trigger", trig, 0);
    swr = 1; wd_stop = 0; tick(); swr = 0;
    chk(stp && !trig, "R4 write ignored while on", stp, 1);
    trace_on = 0; tick();
    swr = 1; wd_stop = 0; tick(); swr = 0;
    chk(!stp, "R4 write clears while off", stp, 0);
    trace_on = 1; ticks(2);

    // error event; event while trigger off ignored
    err_e = 1; tick(); err_e = 0;
    chk(err && !trig, "R3 error clears trigger", trig, 0);
    stop_e = 1; tick(); stop_e = 0;
    chk(!stp, "R3 stop ignored with trigger off", stp, 0);
    trace_on = 0; swr = 1; wd_err = 0; tick(); swr = 0; trace_on = 1; ticks(2);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      trace_on = ($urandom % 10) != 0;
      kern = $urandom % 4 != 0; user = $urandom % 4 != 0;
      asf = $urandom % 3 == 0; br = $urandom % 8 != 0;
      priv = PRIV_W'($urandom); encl = $urandom % 12 == 0;
      ptb = PTB_W'($urandom % 3); ptbm = PTB_W'($urandom % 2);
      hit = $urandom % 5 != 0; fsup = $urandom % 2 == 0;
      stop_e = $urandom % 40 == 0; err_e = $urandom % 50 == 0;
      swr = $urandom % 6 == 0; wd_stop = $urandom % 4 == 0; wd_err = $urandom % 4 == 0;
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule